// File: doc/BRIEF.md
# Cascaded Watchdog Timer with Sticky Stop Lock

This block guards a small processor against runaway firmware. It has a 14-bit down-counter split into two stages: an 8-bit low stage and a 6-bit high stage. The counter is advanced by a divided-down copy of the system clock. It is controlled through one byte-wide register on a plain CPU bus with write strobe, read strobe and data lines. After reset the timer is idle. The first write of any value to the register arms it. Every later write reloads the full count, so firmware must keep writing before the count runs out. If it does not, the block asserts an internal reset request for a fixed number of cycles.

Two register bits shape the behaviour. The source-select bit chooses what decrements the high stage: either the underflow of the low stage, or the prescaler tick directly, which gives a much shorter timeout. The stop-lock bit can be set by software but never cleared by software. Once it is set, a stop request from the core is treated as illegal and causes an internal reset. While the lock is clear, a stop request is granted.

The reset request returns the whole block to its reset values: idle, lock clear, source-select clear, full count. The same holds for the prescaler phase.

Top module: `guard_timer`

## Requirements
- R1: After the external reset, `wdt_rst_o` is 0 and a read returns 0x3F (high stage full, both control bits 0).
- R2: Until the first accepted register write, the counter does not move and no timeout occurs.
- R3: Every accepted write, whatever its data, reloads the low stage to all ones and the high stage to 0x3F. The read-back in the cycle after the write shows 0x3F in bits 5:0.
- R4: With source-select 0, the prescaler ticks decrement the 14-bit chain. The timeout fires on the 16384th tick after the write. Bits 5:0 of the read-back show the upper 6 bits of the remaining count.
- R5: With source-select 1, each prescaler tick decrements the high stage. The timeout fires on the 64th tick. A tick occurs on every clock edge whose index since reset release is a multiple of 2^PRE_W.
- R6: The read byte is {source-select, stop-lock, high stage[5:0]} while `rd_en_i` is 1, and 0 while it is 0. Write data bit 7 sets source-select and bit 6 requests the lock.
- R7: The stop-lock is set-only. A later write with bit 6 at 0 leaves it at 1.
- R8: A stop request with the lock at 0 raises `stop_ack_o` in the same cycle and causes no reset. With the lock at 1, the request gives no acknowledge, and `wdt_rst_o` rises at the next edge.
- R9: The reset request stays high for exactly RST_CYC cycles. Afterwards the block is back in its reset state and idle.
- R10: If a write lands on the same edge as the underflow, the write wins: the counter reloads and no reset is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low external reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_en_i | input | 1 | Register read strobe |
| rd_data_o | output | 8 | Register read data |
| stop_req_i | input | 1 | Stop request from the core |
| stop_ack_o | output | 1 | Stop request granted |
| wdt_rst_o | output | 1 | Internal reset request pulse |

## Verification
The hardest case to reach is a write that lands on exactly the edge where the counter underflows. The bench counts clock edges from reset release and derives the prescaler phase from that count. It can then place the write strobe on the exact underflow edge of a short source-select-1 run. The full 16384-tick timeout is made affordable with a 2-bit prescaler. Along the way, the bench checks the high stage against the arithmetic remaining count on every tick edge.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int HI_W     = 6;
    localparam int LOCK_BIT = 6;
    localparam int SEL_BIT  = 7;
    localparam int REG_W    = 8;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int PRE_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick_o
);
    generate
        if (PRE_W > 0) begin : g_div
            typedef struct packed {
                logic [PRE_W-1:0] cnt;
            } pre_st_t;
            pre_st_t st_d, st_q;

            always_comb begin
                st_d = st_q;
                if (clr) st_d.cnt = '0;
                else     st_d.cnt = st_q.cnt + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) st_q <= '0;
                else        st_q <= st_d;
            end

            assign tick_o = &st_q.cnt;

            // R5: ticks are isolated single-cycle enables
            p_tick_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end else begin : g_nodiv
            logic unused_clr;
            assign unused_clr = clr;
            assign tick_o = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reload,
    input  logic         dec,
    output logic [W-1:0] val_o,
    output logic         uf_o
);
    typedef struct packed {
        logic [W-1:0] val;
    } cnt_st_t;
    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (reload)   st_d.val = '1;
        else if (dec) st_d.val = st_q.val - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.val <= '1;
        else        st_q     <= st_d;
    end

    assign val_o = st_q.val;
    assign uf_o  = dec && (st_q.val == '0);

    // R4: a stage that underflows wraps to all ones
    p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (uf_o && !reload) |=> (val_o == '1));
endmodule

// File: rtl/guard_timer.sv
module guard_timer #(
    parameter int LO_W    = 8,
    parameter int PRE_W   = 4,
    parameter int RST_CYC = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en_i,
    input  logic [7:0] wr_data_i,
    input  logic       rd_en_i,
    output logic [7:0] rd_data_o,
    input  logic       stop_req_i,
    output logic       stop_ack_o,
    output logic       wdt_rst_o
);
    import wdt_pkg::*;

    localparam int RW = $clog2(RST_CYC + 1);

    typedef struct packed {
        logic          armed;
        logic          sel;
        logic          lock;
        logic [RW-1:0] rcnt;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    logic            tick;
    logic            busy;
    logic            wr_eff;
    logic            lo_dec, lo_uf;
    logic            hi_dec, hi_uf;
    logic            bad_stop;
    logic            trig;
    logic            reload;
    logic [LO_W-1:0] lo_val;
    logic [HI_W-1:0] hi_val;
    logic [5:0]      unused_wr_bits;

    assign unused_wr_bits = wr_data_i[5:0];

    wdt_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (busy),
        .tick_o (tick)
    );

    wdt_down_counter #(.W(LO_W)) u_lo (
        .clk    (clk),
        .rst_n  (rst_n),
        .reload (reload),
        .dec    (lo_dec),
        .val_o  (lo_val),
        .uf_o   (lo_uf)
    );

    wdt_down_counter #(.W(HI_W)) u_hi (
        .clk    (clk),
        .rst_n  (rst_n),
        .reload (reload),
        .dec    (hi_dec),
        .val_o  (hi_val),
        .uf_o   (hi_uf)
    );

    always_comb begin
        busy     = (st_q.rcnt != '0);
        wr_eff   = wr_en_i && !busy;
        lo_dec   = st_q.armed && tick;
        hi_dec   = st_q.sel ? lo_dec : lo_uf;
        bad_stop = stop_req_i && st_q.lock && !busy;
        trig     = (hi_uf && !wr_eff) || bad_stop;
        reload   = busy || trig || wr_eff;

        st_d = st_q;
        if (busy) begin
            st_d.rcnt  = st_q.rcnt - 1'b1;
            st_d.armed = 1'b0;
            st_d.sel   = 1'b0;
            st_d.lock  = 1'b0;
        end else if (trig) begin
            st_d.rcnt  = RW'(RST_CYC);
            st_d.armed = 1'b0;
            st_d.sel   = 1'b0;
            st_d.lock  = 1'b0;
        end else if (wr_eff) begin
            st_d.armed = 1'b1;
            st_d.sel   = wr_data_i[SEL_BIT];
            st_d.lock  = st_q.lock | wr_data_i[LOCK_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wdt_rst_o  = busy;
    assign stop_ack_o = stop_req_i && !st_q.lock && !busy;
    assign rd_data_o  = rd_en_i ? {st_q.sel, st_q.lock, hi_val} : 8'h00;

    // R2: an idle timer keeps its count
    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.armed && !wr_en_i && !stop_req_i && !wdt_rst_o) |=> $stable(hi_val) && $stable(lo_val));

    // R3: an accepted write leaves both stages full
    p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wdt_rst_o) |=> (hi_val == '1) && (lo_val == '1));

    // R7: the lock only drops through an internal reset
    p_lock_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.lock && !trig) |=> st_q.lock);

    // R8: an illegal stop request raises the reset at the next edge
    p_bad_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req_i && st_q.lock && !wdt_rst_o) |=> wdt_rst_o);

    // R9: during the reset pulse the block is held in its reset state
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_o |-> (!st_q.armed && !st_q.lock && !st_q.sel && hi_val == '1));

    // R10: a write beats a same-cycle underflow
    p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wdt_rst_o && !(stop_req_i && st_q.lock)) |=> !wdt_rst_o);
endmodule

// File: tb/guard_timer_tb.sv
module guard_timer_tb;
    localparam int PRE_W   = 2;
    localparam int LO_W    = 8;
    localparam int RST_CYC = 5;
    localparam int DIV     = 1 << PRE_W;
    localparam int FULL    = 1 << (LO_W + 6);

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b1;
    logic [7:0] rd_data;
    logic       stop_req = 1'b0;
    logic       stop_ack;
    logic       wdt_rst;

    int tests = 0;
    int fails = 0;
    int n;

    always #5 clk = ~clk;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) n <= 0;
        else        n <= n + 1;
    end

    guard_timer #(.LO_W(LO_W), .PRE_W(PRE_W), .RST_CYC(RST_CYC)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en),
        .wr_data_i  (wr_data),
        .rd_en_i    (rd_en),
        .rd_data_o  (rd_data),
        .stop_req_i (stop_req),
        .stop_ack_o (stop_ack),
        .wdt_rst_o  (wdt_rst)
    );

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [7:0] d, output int w);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        w = n;
    endtask

    // called at the negedge right after the edge that raised the reset
    task automatic pulse_check(input string req);
        for (int i = 0; i < RST_CYC; i++) begin
            check(req, int'(wdt_rst), 1);
            @(negedge clk);
        end
        check(req, int'(wdt_rst), 0);
        check(req, int'(rd_data), 8'h3F);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int w;
        int t;
        int e;
        logic [7:0] vals [4];

        // R1 reset state
        do_reset();
        @(negedge clk);
        check("R1", int'(wdt_rst), 0);
        check("R1", int'(rd_data), 8'h3F);
        rd_en = 1'b0;
        #1;
        check("R6", int'(rd_data), 0);
        rd_en = 1'b1;

        // R2 idle until first write
        repeat (300) @(negedge clk);
        check("R2", int'(rd_data), 8'h3F);
        check("R2", int'(wdt_rst), 0);

        // R5 fast source: every tick checked, timeout on tick 64
        wr(8'h80, w);
        forever begin
            t = n / DIV - w / DIV;
            if (t < 64) begin
                check("R5", int'(rd_data), 8'h80 | (63 - t));
                check("R5", int'(wdt_rst), 0);
            end else begin
                check("R5", int'(wdt_rst), 1);
                break;
            end
            @(negedge clk);
        end
        pulse_check("R9");
        repeat (200) @(negedge clk);
        check("R9", int'(wdt_rst), 0);
        check("R9", int'(rd_data), 8'h3F);

        // R3 reload with varied data, partial countdowns in between
        do_reset();
        vals = '{8'h80, 8'h95, 8'hAA, 8'hBF};
        foreach (vals[k]) begin
            repeat (40) @(negedge clk);
            wr(vals[k], w);
            check("R3", int'(rd_data[5:0]), 8'h3F);
            check("R6", int'(rd_data[7]), 1);
        end

        // R10 write on the exact underflow edge
        do_reset();
        wr(8'h80, w);
        e = (w / DIV + 64) * DIV;
        while (n < e - 1) @(negedge clk);
        wr_en = 1'b1;
        wr_data = 8'h80;
        @(negedge clk);
        wr_en = 1'b0;
        check("R10", n, e);
        check("R10", int'(wdt_rst), 0);
        check("R10", int'(rd_data), 8'hBF);
        repeat (20) begin
            @(negedge clk);
            check("R10", int'(wdt_rst), 0);
        end

        // kicks keep the timer alive (R3)
        for (int k = 0; k < 6; k++) begin
            repeat (200) @(negedge clk);
            check("R3", int'(wdt_rst), 0);
            wr(8'h80, w);
            check("R3", int'(rd_data), 8'hBF);
        end

        // R7 / R8 lock and stop handling
        do_reset();
        @(negedge clk);
        stop_req = 1'b1;
        #1;
        check("R8", int'(stop_ack), 1);
        @(negedge clk);
        stop_req = 1'b0;
        check("R8", int'(wdt_rst), 0);
        wr(8'h40, w);
        check("R7", int'(rd_data), 8'h7F);
        wr(8'h00, w);
        check("R7", int'(rd_data), 8'h7F);
        wr(8'h80, w);
        check("R7", int'(rd_data), 8'hFF);
        stop_req = 1'b1;
        #1;
        check("R8", int'(stop_ack), 0);
        @(negedge clk);
        stop_req = 1'b0;
        check("R8", int'(wdt_rst), 1);
        pulse_check("R9");
        repeat (100) @(negedge clk);
        check("R9", int'(rd_data), 8'h3F);
        check("R9", int'(wdt_rst), 0);

        // R4 full chain timeout
        do_reset();
        wr(8'h00, w);
        forever begin
            t = n / DIV - w / DIV;
            if (t < FULL) begin
                if (n % DIV == 0) begin
                    check("R4", int'(rd_data), (FULL - 1 - t) >> LO_W);
                    check("R4", int'(wdt_rst), 0);
                end
            end else begin
                check("R4", int'(wdt_rst), 1);
                break;
            end
            @(negedge clk);
        end
        pulse_check("R9");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule